// File: doc/BRIEF.md
# Flash-Emulation SPI Command Responder

This block sits behind the SPI device pins and lets an external host treat the chip as a serial NOR flash while the chip is being loaded. Each frame starts with a falling chip select. The block shifts in an opcode, an optional 3-byte address and optional payload on COPI, and shifts response bytes out on CIPO. Status reads, the manufacturer ID read and the write-enable latch are handled inside the block. Erase, program and reset requests leave through a valid/ready command port, and program payload bytes leave through a one-cycle byte strobe.

SPI mode 0 is used: COPI is sampled on the rising serial clock edge and CIPO changes on the falling edge. The serial clock, chip select and COPI inputs must already be synchronous to `clk`, and the serial clock must be slower than `clk` by a factor of at least four. When bootstrap is not active, the host reads all-ones no matter what it sends. A frame cut short by chip select is discarded.

Top module: `spi_emu_responder`

## Requirements
- R1: While `boot_active` is low, every CIPO bit of every frame is 1. No command is forwarded and no payload strobe is raised. Write-enable and write-disable opcodes have no effect.
- R2: Opcode 0x05 returns the status byte in every byte slot after the opcode. The status byte has bit 1 = write-enable latch, bit 0 = command pending, and all other bits 0. It reads 0x00 after reset.
- R3: Opcode 0x06 sets the latch, so a later status read returns 0x02. Opcode 0x04 clears it, so a later status read returns 0x00.
- R4: Opcode 0x9F returns 0x7F in slots 1 to 12, then 0xEF in slot 13, then 0x14 in slot 14, and 0xFF in any later slot.
- R5: Opcode 0x03 takes a 3-byte address and answers 0xFF in every slot. Nothing is forwarded.
- R6: Opcodes 0xC7 and 0x99 are forwarded when chip select rises after a complete opcode byte. They are forwarded with address 0 and length 0, and only these forwardable opcodes (0x20, 0xC7, 0x02, 0x99) ever appear on the command port.
- R7: Opcode 0x20 is forwarded with its address assembled big-endian (first byte = bits 23:16). This happens only if all three address bytes arrived. A shorter frame forwards nothing.
- R8: Opcode 0x02 with a complete address forwards that address. Payload bytes that follow appear one per strobe, in order, with indices counting from 0. At most 256 bytes are accepted, and the command length equals the number of accepted bytes.
- R9: A forwarded command holds valid and stable fields until `cmd_ready`. While it waits, status bit 0 reads 1, and any new frame that would forward is discarded.
- R10: Acceptance of a forwarded 0x20, 0xC7 or 0x02 clears the write-enable latch. Acceptance of 0x99 leaves it unchanged.
- R11: CIPO is 1 while chip select is high and during the opcode byte. Unknown opcodes answer 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_active | input | 1 | Bootstrap mode enabled and requested |
| spi_sclk | input | 1 | Serial clock, synchronous to clk |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_copi | input | 1 | Serial data from host |
| spi_cipo | output | 1 | Serial data to host |
| cmd_valid | output | 1 | Forwarded command pending |
| cmd_ready | input | 1 | Downstream accepts command |
| cmd_op | output | 8 | Forwarded opcode |
| cmd_addr | output | 24 | Forwarded address |
| cmd_len | output | 9 | Accepted payload byte count |
| pld_valid | output | 1 | Payload byte strobe |
| pld_data | output | 8 | Payload byte |
| pld_idx | output | 8 | Payload byte index within the page |

## Verification
Two events can land in the same cycle. The first is the downstream acceptance of a pending program command, which clears both the pending bit and the write-enable latch. The second is the capture of the next status byte during a long status read. The bench holds `cmd_ready` low after a program frame, then starts an eight-byte status read and raises `cmd_ready` at a random cycle in the middle of it. The bench judges the result by requiring that each status byte is either 0x03 or 0x00, that the bytes never go back from 0x00 to 0x03, and that the sequence starts at 0x03 and ends at 0x00.

// File: rtl/spi_emu_pkg.sv
package spi_emu_pkg;

    localparam logic [7:0] OP_RD_STATUS  = 8'h05;
    localparam logic [7:0] OP_WR_EN      = 8'h06;
    localparam logic [7:0] OP_WR_DIS     = 8'h04;
    localparam logic [7:0] OP_RD_ID      = 8'h9F;
    localparam logic [7:0] OP_READ       = 8'h03;
    localparam logic [7:0] OP_SEC_ERASE  = 8'h20;
    localparam logic [7:0] OP_CHIP_ERASE = 8'hC7;
    localparam logic [7:0] OP_PROGRAM    = 8'h02;
    localparam logic [7:0] OP_RESET      = 8'h99;

    localparam int ADDR_BYTES = 3;
    localparam int ADDR_W     = 8 * ADDR_BYTES;

    typedef enum logic [2:0] {
        CLS_LOCAL,
        CLS_PLAIN_FWD,
        CLS_ADDR_FWD,
        CLS_PROGRAM,
        CLS_OTHER
    } op_class_e;

    typedef struct packed {
        logic [7:0]        op;
        logic [ADDR_W-1:0] addr;
    } cmd_t;

    function automatic op_class_e classify(input logic [7:0] op);
        case (op)
            OP_RD_STATUS, OP_WR_EN, OP_WR_DIS, OP_RD_ID: return CLS_LOCAL;
            OP_CHIP_ERASE, OP_RESET:                     return CLS_PLAIN_FWD;
            OP_SEC_ERASE:                                return CLS_ADDR_FWD;
            OP_PROGRAM:                                  return CLS_PROGRAM;
            default:                                     return CLS_OTHER;
        endcase
    endfunction

    function automatic logic drops_wel(input logic [7:0] op);
        return (op == OP_SEC_ERASE) || (op == OP_CHIP_ERASE) || (op == OP_PROGRAM);
    endfunction

endpackage

// File: rtl/spi_emu_shifter.sv
module spi_emu_shifter (
    input  logic       clk,
    input  logic       rst,
    input  logic       sclk,
    input  logic       cs_n,
    input  logic       copi,
    input  logic [7:0] resp,
    output logic       cipo,
    output logic       byte_done,
    output logic [7:0] rx_byte,
    output logic       cs_rise,
    output logic       cs_idle
);
    logic       sclk_q, cs_q;
    logic [2:0] bit_q;
    logic [6:0] sh_q;
    logic [7:0] tx_q;
    logic       rise, fall;

    assign rise    = sclk & ~sclk_q & ~cs_n;
    assign fall    = ~sclk & sclk_q & ~cs_n;
    assign cs_rise = cs_n & ~cs_q;
    assign cs_idle = cs_q;
    assign cipo    = tx_q[7];

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q    <= 1'b0;
            cs_q      <= 1'b1;
            bit_q     <= '0;
            sh_q      <= '0;
            tx_q      <= 8'hFF;
            byte_done <= 1'b0;
            rx_byte   <= '0;
        end else begin
            sclk_q    <= sclk;
            cs_q      <= cs_n;
            byte_done <= 1'b0;
            if (cs_n) begin
                bit_q <= '0;
                tx_q  <= 8'hFF;
            end else begin
                if (rise) begin
                    sh_q  <= {sh_q[5:0], copi};
                    bit_q <= bit_q + 3'd1;
                    if (bit_q == 3'd7) begin
                        byte_done <= 1'b1;
                        rx_byte   <= {sh_q, copi};
                    end
                end
                if (fall) begin
                    // a new response byte starts at each byte boundary
                    tx_q <= (bit_q == 3'd0) ? resp : {tx_q[6:0], 1'b1};
                end
            end
        end
    end
endmodule

// File: rtl/spi_emu_decoder.sv
module spi_emu_decoder
    import spi_emu_pkg::*;
#(
    parameter int          PAGE_BYTES = 256,
    parameter int          CONT_CODES = 12,
    parameter logic [7:0]  MFR_ID     = 8'hEF,
    parameter logic [7:0]  DENSITY    = 8'h14,
    parameter int          LEN_W      = $clog2(PAGE_BYTES + 1),
    parameter int          PIDX_W     = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic              byte_done,
    input  logic [7:0]        rx_byte,
    input  logic              cs_rise,
    input  logic              cs_idle,
    output logic [7:0]        resp,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output cmd_t              cmd,
    output logic [LEN_W-1:0]  cmd_len,
    output logic              pld_valid,
    output logic [7:0]        pld_data,
    output logic [PIDX_W-1:0] pld_idx
);
    localparam int IDX_W = $clog2(PAGE_BYTES + CONT_CODES + 8) + 1;

    logic [IDX_W-1:0]  idx_q, slot;
    logic [7:0]        op_q, cur_op, status, next_resp;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  cnt_q;
    logic              wel_q, fwd_ok_q, launch, take;
    op_class_e         cls;

    assign cur_op = (idx_q == '0) ? rx_byte : op_q;
    assign slot   = idx_q + IDX_W'(1);
    assign status = {6'b0, wel_q, cmd_valid};
    assign cls    = classify(op_q);

    always_comb begin
        next_resp = 8'hFF;
        if (active) begin
            case (cur_op)
                OP_RD_STATUS: next_resp = status;
                OP_RD_ID: begin
                    if (slot <= IDX_W'(CONT_CODES))          next_resp = 8'h7F;
                    else if (slot == IDX_W'(CONT_CODES + 1)) next_resp = MFR_ID;
                    else if (slot == IDX_W'(CONT_CODES + 2)) next_resp = DENSITY;
                end
                default: next_resp = 8'hFF;
            endcase
        end
    end

    always_comb begin
        case (cls)
            CLS_PLAIN_FWD:            launch = (idx_q >= IDX_W'(1));
            CLS_ADDR_FWD, CLS_PROGRAM: launch = (idx_q >= IDX_W'(1 + ADDR_BYTES));
            default:                  launch = 1'b0;
        endcase
        launch = launch && fwd_ok_q && active && !cmd_valid;
    end

    assign take = fwd_ok_q && active && (cls == CLS_PROGRAM) && (cnt_q < LEN_W'(PAGE_BYTES));

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q     <= '0;
            op_q      <= '0;
            addr_q    <= '0;
            cnt_q     <= '0;
            wel_q     <= 1'b0;
            fwd_ok_q  <= 1'b0;
            resp      <= 8'hFF;
            cmd_valid <= 1'b0;
            cmd       <= '0;
            cmd_len   <= '0;
            pld_valid <= 1'b0;
            pld_data  <= '0;
            pld_idx   <= '0;
        end else begin
            pld_valid <= 1'b0;
            if (cmd_valid && cmd_ready) begin
                cmd_valid <= 1'b0;
                if (drops_wel(cmd.op)) wel_q <= 1'b0;
            end
            if (cs_idle) begin
                idx_q    <= '0;
                cnt_q    <= '0;
                addr_q   <= '0;
                fwd_ok_q <= 1'b0;
                resp     <= 8'hFF;
            end else if (byte_done) begin
                resp <= next_resp;
                if (idx_q != '1) idx_q <= idx_q + IDX_W'(1);
                if (idx_q == '0) begin
                    op_q     <= rx_byte;
                    fwd_ok_q <= active && !cmd_valid;
                    if (active && rx_byte == OP_WR_EN)       wel_q <= 1'b1;
                    else if (active && rx_byte == OP_WR_DIS) wel_q <= 1'b0;
                end else if (idx_q <= IDX_W'(ADDR_BYTES)) begin
                    addr_q <= {addr_q[ADDR_W-9:0], rx_byte};
                end else if (take) begin
                    pld_valid <= 1'b1;
                    pld_data  <= rx_byte;
                    pld_idx   <= cnt_q[PIDX_W-1:0];
                    cnt_q     <= cnt_q + LEN_W'(1);
                end
            end
            if (cs_rise && launch) begin
                cmd_valid <= 1'b1;
                cmd.op    <= op_q;
                cmd.addr  <= (cls == CLS_PLAIN_FWD) ? '0 : addr_q;
                cmd_len   <= (cls == CLS_PROGRAM) ? cnt_q : '0;
            end
        end
    end
endmodule

// File: rtl/spi_emu_responder.sv
module spi_emu_responder
    import spi_emu_pkg::*;
#(
    parameter int         PAGE_BYTES = 256,
    parameter int         CONT_CODES = 12,
    parameter logic [7:0] MFR_ID     = 8'hEF,
    parameter logic [7:0] DENSITY    = 8'h14,
    localparam int        LEN_W      = $clog2(PAGE_BYTES + 1),
    localparam int        PIDX_W     = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              boot_active,
    input  logic              spi_sclk,
    input  logic              spi_cs_n,
    input  logic              spi_copi,
    output logic              spi_cipo,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [7:0]        cmd_op,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [LEN_W-1:0]  cmd_len,
    output logic              pld_valid,
    output logic [7:0]        pld_data,
    output logic [PIDX_W-1:0] pld_idx
);
    logic       byte_done, cs_rise, cs_idle;
    logic [7:0] rx_byte, resp;
    cmd_t       cmd;

    spi_emu_shifter u_shift (
        .clk       (clk),
        .rst       (rst),
        .sclk      (spi_sclk),
        .cs_n      (spi_cs_n),
        .copi      (spi_copi),
        .resp      (resp),
        .cipo      (spi_cipo),
        .byte_done (byte_done),
        .rx_byte   (rx_byte),
        .cs_rise   (cs_rise),
        .cs_idle   (cs_idle)
    );

    spi_emu_decoder #(
        .PAGE_BYTES (PAGE_BYTES),
        .CONT_CODES (CONT_CODES),
        .MFR_ID     (MFR_ID),
        .DENSITY    (DENSITY),
        .LEN_W      (LEN_W),
        .PIDX_W     (PIDX_W)
    ) u_dec (
        .clk       (clk),
        .rst       (rst),
        .active    (boot_active),
        .byte_done (byte_done),
        .rx_byte   (rx_byte),
        .cs_rise   (cs_rise),
        .cs_idle   (cs_idle),
        .resp      (resp),
        .cmd_valid (cmd_valid),
        .cmd_ready (cmd_ready),
        .cmd       (cmd),
        .cmd_len   (cmd_len),
        .pld_valid (pld_valid),
        .pld_data  (pld_data),
        .pld_idx   (pld_idx)
    );

    assign cmd_op   = cmd.op;
    assign cmd_addr = cmd.addr;
endmodule

// File: rtl/spi_emu_checker.sv
module spi_emu_checker #(
    parameter int LEN_W = 9
) (
    input logic             clk,
    input logic             rst,
    input logic             boot_active,
    input logic             spi_cs_n,
    input logic             spi_cipo,
    input logic             cmd_valid,
    input logic             cmd_ready,
    input logic [7:0]       cmd_op,
    input logic [23:0]      cmd_addr,
    input logic [LEN_W-1:0] cmd_len,
    input logic             pld_valid
);
    // R11
    idle_cipo_chk: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n && $past(spi_cs_n) |-> spi_cipo);

    // R9
    cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op) && $stable(cmd_addr) && $stable(cmd_len));

    // R1
    cmd_launch_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cmd_valid) |-> spi_cs_n && $past(boot_active));

    // R6
    cmd_op_legal_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> (cmd_op == 8'h20 || cmd_op == 8'hC7 || cmd_op == 8'h02 || cmd_op == 8'h99));

    // R8
    pld_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
        pld_valid |-> !$past(spi_cs_n));
endmodule

bind spi_emu_responder spi_emu_checker #(.LEN_W(LEN_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .boot_active (boot_active),
    .spi_cs_n    (spi_cs_n),
    .spi_cipo    (spi_cipo),
    .cmd_valid   (cmd_valid),
    .cmd_ready   (cmd_ready),
    .cmd_op      (cmd_op),
    .cmd_addr    (cmd_addr),
    .cmd_len     (cmd_len),
    .pld_valid   (pld_valid)
);

// File: tb/test_spi_emu_responder.sv
module test_spi_emu_responder;
    localparam int HALF = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic boot_active = 1'b0;
    logic spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_copi = 1'b0;
    logic spi_cipo, cmd_valid, pld_valid;
    logic cmd_ready = 1'b1;
    logic [7:0] cmd_op, pld_data, pld_idx;
    logic [23:0] cmd_addr;
    logic [8:0] cmd_len;

    always #2 clk = ~clk;

    spi_emu_responder i_spi_emu_responder (
        .clk(clk), .rst(rst), .boot_active(boot_active),
        .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_copi(spi_copi), .spi_cipo(spi_cipo),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
        .cmd_len(cmd_len), .pld_valid(pld_valid), .pld_data(pld_data), .pld_idx(pld_idx)
    );

    int n_checks = 0, n_fail = 0;
    logic [7:0] tx_buf [0:319];
    logic [7:0] rx_buf [0:319];
    logic [7:0] log_op [0:63];
    logic [23:0] log_addr [0:63];
    logic [8:0] log_len [0:63];
    int log_n = 0;
    logic [7:0] pld_log [0:319];
    int pld_n = 0;
    bit pld_idx_bad = 0;
    bit m_wel = 0;

    always @(negedge clk) begin
        if (cmd_valid && cmd_ready && log_n < 64) begin
            log_op[log_n] = cmd_op; log_addr[log_n] = cmd_addr; log_len[log_n] = cmd_len;
            log_n++;
        end
        if (pld_valid && pld_n < 320) begin
            if (pld_idx != pld_n[7:0]) pld_idx_bad = 1;
            pld_log[pld_n] = pld_data;
            pld_n++;
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic spi_frame(input int n);
        @(negedge clk) spi_cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int b = 0; b < n; b++) begin
            logic [7:0] r;
            r = '0;
            for (int i = 7; i >= 0; i--) begin
                spi_copi = tx_buf[b][i];
                repeat (HALF) @(negedge clk);
                r = {r[6:0], spi_cipo};
                spi_sclk = 1'b1;
                repeat (HALF) @(negedge clk);
                spi_sclk = 1'b0;
            end
            rx_buf[b] = r;
        end
        repeat (HALF) @(negedge clk);
        spi_cs_n = 1'b1;
        repeat (HALF) @(negedge clk);
    endtask

    function automatic logic [7:0] exp_resp(input logic [7:0] op, input int slot,
                                            input bit act, input bit wel, input bit busy);
        if (!act || slot == 0) return 8'hFF;
        if (op == 8'h05) return {6'b0, wel, busy};
        if (op == 8'h9F) begin
            if (slot <= 12) return 8'h7F;
            if (slot == 13) return 8'hEF;
            if (slot == 14) return 8'h14;
        end
        return 8'hFF;
    endfunction

    function automatic string resp_tag(input logic [7:0] op, input bit act);
        if (!act) return "R1";
        case (op)
            8'h05: return "R2";
            8'h9F: return "R4";
            8'h03: return "R5";
            default: return "R11";
        endcase
    endfunction

    function automatic string fwd_tag(input logic [7:0] op, input bit act);
        if (!act) return "R1";
        case (op)
            8'h20: return "R7";
            8'h02: return "R8";
            8'hC7, 8'h99: return "R6";
            default: return "R5";
        endcase
    endfunction

    // one frame with cmd_ready held high; the model predicts responses and forwarding
    task automatic run_frame(input logic [7:0] op, input int n, input bit act);
        bit fwd;
        logic [23:0] e_addr;
        int e_len, bad;
        logic [7:0] got, want;
        boot_active = act;
        tx_buf[0] = op;
        for (int k = 1; k < n; k++) tx_buf[k] = 8'($urandom);
        log_n = 0; pld_n = 0; pld_idx_bad = 0;
        spi_frame(n);
        repeat (8) @(negedge clk);
        bad = -1;
        for (int k = 0; k < n; k++)
            if (bad < 0 && rx_buf[k] != exp_resp(op, k, act, m_wel, 1'b0)) bad = k;
        got = (bad < 0) ? 8'h00 : rx_buf[bad];
        want = (bad < 0) ? 8'h00 : exp_resp(op, bad, act, m_wel, 1'b0);
        chk(bad < 0, resp_tag(op, act), $sformatf("op %0h response byte %0d", op, bad), got, want);
        if (act && op == 8'h06) m_wel = 1;
        if (act && op == 8'h04) m_wel = 0;
        fwd = act && (((op == 8'hC7 || op == 8'h99) && n >= 1) || ((op == 8'h20 || op == 8'h02) && n >= 4));
        e_addr = (op == 8'h20 || op == 8'h02) ? {tx_buf[1], tx_buf[2], tx_buf[3]} : 24'h0;
        e_len = (op == 8'h02 && fwd) ? ((n - 4 > 256) ? 256 : n - 4) : 0;
        chk(log_n == int'(fwd), fwd_tag(op, act), $sformatf("op %0h forwarded count", op), log_n, fwd);
        if (fwd && log_n == 1) begin
            chk(log_op[0] == op && log_addr[0] == e_addr && log_len[0] == 9'(e_len), fwd_tag(op, act),
                "forwarded fields", {log_op[0], log_addr[0]}, {op, e_addr});
            if (op != 8'h99) m_wel = 0;
        end
        chk(pld_n == e_len && !pld_idx_bad, "R8", "payload byte count", pld_n, e_len);
        bad = -1;
        for (int k = 0; k < pld_n && k < e_len; k++)
            if (bad < 0 && pld_log[k] != tx_buf[k + 4]) bad = k;
        if (e_len > 0)
            chk(bad < 0, "R8", "payload bytes", (bad < 0) ? 0 : pld_log[bad], (bad < 0) ? 0 : tx_buf[bad + 4]);
    endtask

    task automatic status_read(output logic [7:0] s);
        tx_buf[0] = 8'h05;
        spi_frame(2);
        s = rx_buf[1];
    endtask

    initial begin
        logic [7:0] s;
        int delay, seen_zero, mono_bad;
        void'($urandom(32'd7331));
        repeat (5) @(negedge clk);
        chk(spi_cipo == 1'b1 && cmd_valid == 1'b0 && pld_valid == 1'b0, "R11", "outputs in reset",
            {spi_cipo, cmd_valid, pld_valid}, 3'b100);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // directed corners
        run_frame(8'h05, 3, 1'b1);                  // R2 reset status 0x00
        run_frame(8'h06, 1, 1'b1);                  // R3
        run_frame(8'h05, 2, 1'b1);                  // R3 reads 0x02
        run_frame(8'h04, 1, 1'b1);
        run_frame(8'h05, 2, 1'b1);                  // R3 reads 0x00
        run_frame(8'h9F, 17, 1'b1);                 // R4 full ID plus trailing 0xFF
        run_frame(8'h03, 8, 1'b1);                  // R5
        run_frame(8'h06, 1, 1'b0);                  // R1 inactive write enable ignored
        run_frame(8'h05, 3, 1'b0);                  // R1 status all ones
        run_frame(8'hC7, 1, 1'b0);                  // R1 nothing forwarded
        run_frame(8'h05, 2, 1'b1);                  // R1 latch still clear
        run_frame(8'h20, 3, 1'b1);                  // R7 truncated address
        run_frame(8'h06, 1, 1'b1);
        run_frame(8'h02, 304, 1'b1);                // R8 page limit, R10 latch cleared
        run_frame(8'h05, 2, 1'b1);
        run_frame(8'h06, 1, 1'b1);
        run_frame(8'h99, 1, 1'b1);                  // R10 reset keeps latch
        run_frame(8'h05, 2, 1'b1);
        run_frame(8'h5A, 3, 1'b1);                  // R11 unknown opcode

        // R9 pending command: busy bit, hold, and drop of a second frame
        boot_active = 1'b1;
        @(negedge clk) cmd_ready = 1'b0;
        tx_buf[0] = 8'h06; spi_frame(1);
        tx_buf[0] = 8'hC7; spi_frame(1);
        chk(cmd_valid == 1'b1, "R9", "command pending", cmd_valid, 1);
        status_read(s);
        chk(s == 8'h03, "R9", "status while pending", s, 8'h03);
        tx_buf[0] = 8'h20; tx_buf[1] = 8'h12; tx_buf[2] = 8'h34; tx_buf[3] = 8'h56; spi_frame(4);
        log_n = 0;
        @(negedge clk) cmd_ready = 1'b1;
        repeat (4) @(negedge clk);
        chk(log_n == 1 && log_op[0] == 8'hC7, "R9", "only first command delivered", log_n, 1);
        status_read(s);
        chk(s == 8'h00, "R10", "status after erase accepted", s, 8'h00);
        m_wel = 0;

        // coincidence: acceptance during a running status read
        @(negedge clk) cmd_ready = 1'b0;
        tx_buf[0] = 8'h06; spi_frame(1);
        tx_buf[0] = 8'h02; spi_frame(5);
        delay = 100 + int'($urandom % 300);
        fork
            begin tx_buf[0] = 8'h05; spi_frame(8); end
            begin repeat (delay) @(negedge clk); cmd_ready = 1'b1; end
        join
        seen_zero = 0; mono_bad = 0;
        for (int k = 1; k < 8; k++) begin
            if (rx_buf[k] != 8'h03 && rx_buf[k] != 8'h00) mono_bad = 1;
            if (rx_buf[k] == 8'h00) seen_zero = 1;
            else if (seen_zero) mono_bad = 1;
        end
        chk(!mono_bad && rx_buf[1] == 8'h03 && rx_buf[7] == 8'h00, "R9",
            "status across acceptance", {rx_buf[1], rx_buf[7]}, 16'h0300);
        m_wel = 0;

        // constrained random frames
        for (int t = 0; t < 45; t++) begin
            logic [7:0] op;
            int n, pick;
            bit act;
            pick = int'($urandom % 10);
            act = ($urandom % 8) != 0;
            case (pick)
                0: begin op = 8'h05; n = 2 + int'($urandom % 4); end
                1: begin op = 8'h06; n = 1; end
                2: begin op = 8'h04; n = 1; end
                3: begin op = 8'h9F; n = 1 + int'($urandom % 17); end
                4: begin op = 8'h03; n = 4 + int'($urandom % 5); end
                5: begin op = 8'h20; n = 2 + int'($urandom % 5); end
                6: begin op = 8'hC7; n = 1 + int'($urandom % 2); end
                7: begin op = 8'h02; n = 2 + int'($urandom % 24); end
                8: begin op = 8'h99; n = 1; end
                default: begin op = 8'hA5 ^ 8'($urandom % 4); n = 1 + int'($urandom % 3); end
            endcase
            run_frame(op, n, act);
        end
        summary();
    end
endmodule